// File: doc/BRIEF.md
# Interleaved Column Data Serializer

This block feeds the anode shift registers of a dot-matrix vacuum fluorescent panel during grid scanning. On a start strobe it takes the current scan step, works out which step comes next, and streams that step's anode payload out over a serial data line and a shift clock. The data is shifted while the current step is on show, so the display can latch it when the next step begins.

The panel groups its columns in fours, lettered A, B, C and D by column number modulo four. Each scan step shows two columns three apart. On one step parity the pair is an A and a D column; on the other it is a C and a B column. The payload therefore does not leave in raster order. Row by row, it alternates between the leading and the trailing column of the pair.

The block fetches the pixels one 16-bit word at a time from a frame-buffer read port. The port has a one-cycle read latency. Grid drive, latch and blank timing are handled elsewhere.

Top module: `vfd_col_serializer`

## Requirements
- R1: While reset is held, shiftClk, serData and done are all 0.
- R2: Each accepted start produces exactly 2*ROWS rising edges of shiftClk (128 with defaults). shiftClk is low whenever done is high.
- R3: For a start with stepIdx = s, the loaded step is n = (s+1) mod (COLS/2). Its leading column is 2n and its trailing column is (2n+3) mod COLS.
- R4: Bits leave in ascending row order. For each row, the leading column's pixel goes first and the trailing column's pixel follows.
- R5: Letters are column mod 4 (0 = A, 1 = B, 2 = C, 3 = D). An even n sends an A/D-interleaved payload and an odd n sends a C/B-interleaved payload.
- R6: The pixel at (column c, row r) is bit r mod 16 of frame-buffer word c*(ROWS/16) + r/16. rdData returns the word addressed one clock earlier.
- R7: serData changes only while shiftClk is low, and it is stable while shiftClk is high. The display samples on the rising edge.
- R8: done is a single-cycle pulse, given once per accepted start, one cycle after the falling edge of shiftClk that ends the last bit.
- R9: A start strobe that arrives while a transfer is in progress is ignored. It changes neither the payload nor the count of bits or done pulses.
- R10: Steps wrap around. Step COLS/2-1 loads step 0, and when step COLS/2-2 loads the last step, the trailing column wraps to column 1.
- R11: Each shiftClk high phase lasts CLK_DIV clock cycles, and each low phase lasts at least CLK_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, one cycle |
| stepIdx | input | $clog2(COLS/2) | Scan step now being shown |
| rdAddr | output | $clog2(COLS*ROWS/16) | Frame-buffer word address |
| rdData | input | 16 | Frame-buffer word, one cycle after the address |
| serData | output | 1 | Serial anode data |
| shiftClk | output | 1 | Shift clock; the display samples on its rising edge |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
The bench runs four kinds of frame. A pseudo-random frame catches any swap of rows, words or bit positions. A letter-coded frame (every A column lit and D columns lit on odd rows) tells an A/D payload from a C/B payload and shows whether the leading and trailing slots were swapped. A diagonal frame gives each column a single lit row, so an off-by-one in the step or column selection shows up. The wrap steps, 62 and 63, are driven on their own. A second start is sent in the middle of a transfer to show that it leaves the payload and the done count unchanged.

// File: rtl/colser_pkg.sv
package colser_pkg;
  // Per-cycle commands from the control FSM to the shifting datapath.
  typedef struct packed {
    logic loadFirst;   // capture rdData as the leading-column word
    logic loadSecond;  // capture rdData as the trailing-column word
    logic putBit;      // present the next bit, shift clock low
    logic raiseClk;    // shift clock high
    logic dropClk;     // shift clock low after the last bit of a word pair
  } serStrobe_t;
endpackage

// File: rtl/colser_ctrl.sv
module colser_ctrl
  import colser_pkg::*;
#(
  parameter int COLS    = 128,
  parameter int ROWS    = 64,
  parameter int WORD_W  = 16,
  parameter int CLK_DIV = 2,
  localparam int STEPS  = COLS / 2,
  localparam int WPC    = ROWS / WORD_W,
  localparam int STEP_W = $clog2(STEPS),
  localparam int ADDR_W = $clog2(COLS * WPC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [STEP_W-1:0] stepIdx,
  output logic [ADDR_W-1:0] rdAddr,
  output serStrobe_t        strobe,
  output logic              done
);
  localparam int COL_W  = STEP_W + 1;
  localparam int WSEL_W = (WPC > 1) ? $clog2(WPC) : 1;
  localparam int BIT_W  = $clog2(2 * WORD_W);
  localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_RD2, S_RD3, S_LOW, S_HIGH, S_FIN} state_t;

  state_t             state, stateNxt;
  logic [STEP_W-1:0]  nextStep;
  logic [WSEL_W-1:0]  wordIdx;
  logic [BIT_W-1:0]   bitCnt;
  logic [DIV_W-1:0]   divCnt;
  logic [COL_W-1:0]   leadCol, trailCol, curCol;
  logic               divDone, lastBit, lastWord;

  // Leading column is 2n; trailing is three further on, wrapping modulo COLS.
  assign leadCol  = {nextStep, 1'b0};
  assign trailCol = leadCol + COL_W'(3);
  assign curCol   = (state == S_RD2) ? trailCol : leadCol;
  assign rdAddr   = ADDR_W'(curCol) * ADDR_W'(WPC) + ADDR_W'(wordIdx);

  assign divDone  = (divCnt == DIV_W'(CLK_DIV - 1));
  assign lastBit  = (bitCnt == BIT_W'(2 * WORD_W - 1));
  assign lastWord = (wordIdx == WSEL_W'(WPC - 1));
  assign done     = (state == S_FIN);

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      S_IDLE: if (start) stateNxt = S_RD1;
      S_RD1:  stateNxt = S_RD2;
      S_RD2: begin
        strobe.loadFirst = 1'b1;
        stateNxt = S_RD3;
      end
      S_RD3: begin
        strobe.loadSecond = 1'b1;
        strobe.putBit     = 1'b1;
        stateNxt = S_LOW;
      end
      S_LOW: if (divDone) begin
        strobe.raiseClk = 1'b1;
        stateNxt = S_HIGH;
      end
      S_HIGH: if (divDone) begin
        if (lastBit) begin
          strobe.dropClk = 1'b1;
          stateNxt = lastWord ? S_FIN : S_RD1;
        end else begin
          strobe.putBit = 1'b1;
          stateNxt = S_LOW;
        end
      end
      S_FIN:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      nextStep <= '0;
      wordIdx  <= '0;
      bitCnt   <= '0;
      divCnt   <= '0;
    end else begin
      state <= stateNxt;
      if ((state == S_LOW || state == S_HIGH) && !divDone) divCnt <= divCnt + DIV_W'(1);
      else divCnt <= '0;
      if (state == S_IDLE && start) begin
        nextStep <= stepIdx + STEP_W'(1);
        wordIdx  <= '0;
        bitCnt   <= '0;
      end else if (state == S_HIGH && divDone) begin
        if (lastBit) begin
          bitCnt  <= '0;
          wordIdx <= wordIdx + WSEL_W'(1);
        end else begin
          bitCnt <= bitCnt + BIT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/colser_dp.sv
module colser_dp
  import colser_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  serStrobe_t        strobe,
  input  logic [WORD_W-1:0] rdData,
  output logic              serData,
  output logic              shiftClk
);
  logic [WORD_W-1:0] leadSh, trailSh;
  logic              pickTrail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leadSh    <= '0;
      trailSh   <= '0;
      pickTrail <= 1'b0;
      serData   <= 1'b0;
      shiftClk  <= 1'b0;
    end else begin
      if (strobe.loadFirst) begin
        leadSh    <= rdData;
        pickTrail <= 1'b0;
      end
      if (strobe.loadSecond) trailSh <= rdData;
      if (strobe.putBit) begin
        serData   <= pickTrail ? trailSh[0] : leadSh[0];
        shiftClk  <= 1'b0;
        pickTrail <= ~pickTrail;
        if (pickTrail) begin
          leadSh  <= leadSh >> 1;
          trailSh <= trailSh >> 1;
        end
      end
      if (strobe.raiseClk) shiftClk <= 1'b1;
      if (strobe.dropClk)  shiftClk <= 1'b0;
    end
  end
endmodule

// File: rtl/vfd_col_serializer.sv
module vfd_col_serializer
  import colser_pkg::*;
#(
  parameter int COLS    = 128,
  parameter int ROWS    = 64,
  parameter int WORD_W  = 16,
  parameter int CLK_DIV = 2,
  localparam int STEP_W = $clog2(COLS / 2),
  localparam int ADDR_W = $clog2(COLS * (ROWS / WORD_W))
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [STEP_W-1:0] stepIdx,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [WORD_W-1:0] rdData,
  output logic              serData,
  output logic              shiftClk,
  output logic              done
);
  serStrobe_t strobe;

  colser_ctrl #(.COLS(COLS), .ROWS(ROWS), .WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stepIdx(stepIdx),
    .rdAddr(rdAddr), .strobe(strobe), .done(done)
  );

  colser_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(rdData),
    .serData(serData), .shiftClk(shiftClk)
  );
endmodule

// File: rtl/colser_chk.sv
module colser_chk (
  input logic clk,
  input logic rstN,
  input logic serData,
  input logic shiftClk,
  input logic done
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (shiftClk && $past(shiftClk)) |-> $stable(serData)); // R7
  AST_MOVE_ONLY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serData) |-> !shiftClk); // R7
  AST_RISE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftClk) |-> $stable(serData)); // R7
  AST_DONE_CLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !shiftClk); // R2
endmodule

bind vfd_col_serializer colser_chk u_chk (
  .clk(clk), .rstN(rstN), .serData(serData), .shiftClk(shiftClk), .done(done)
);

// File: tb/vfd_col_serializer_tb.sv
`timescale 1ns/1ps
module vfd_col_serializer_tb;
  localparam int COLS = 128, ROWS = 64, WORD_W = 16, DIV = 2;
  localparam int STEPS = COLS / 2, WPC = ROWS / WORD_W, NBITS = 2 * ROWS;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [5:0]  stepIdx = '0;
  logic [8:0]  rdAddr;
  logic [15:0] rdData;
  logic serData, shiftClk, done;

  logic [15:0] fb [0:COLS*WPC-1];
  always_ff @(posedge clk) rdData <= fb[rdAddr];

  vfd_col_serializer #(.COLS(COLS), .ROWS(ROWS), .WORD_W(WORD_W), .CLK_DIV(DIV)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .stepIdx(stepIdx), .rdAddr(rdAddr),
    .rdData(rdData), .serData(serData), .shiftClk(shiftClk), .done(done)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic capBits [0:255];
  int capCnt = 0, doneCnt = 0, doneWide = 0, holdErr = 0, widthErr = 0, lowErr = 0;
  int highRun = 0, lowRun = 0, highSeen = 0;
  logic prevClk = 0, prevDone = 0, prevData = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevClk = 0; prevDone = 0; prevData = 0; highRun = 0; lowRun = 0;
    end else begin
      if (shiftClk && !prevClk) begin
        if (capCnt < 256) capBits[capCnt] = serData;
        capCnt++;
      end
      if (shiftClk && prevClk && serData !== prevData) holdErr++;
      if (shiftClk) begin
        if (!prevClk && lowRun < DIV) lowErr++;
        highRun++; lowRun = 0;
      end else begin
        if (prevClk) begin
          highSeen++;
          if (highRun != DIV) widthErr++;
        end
        highRun = 0; lowRun++;
      end
      if (done) begin
        doneCnt++;
        if (prevDone) doneWide++;
      end
      prevClk = shiftClk; prevDone = done; prevData = serData;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pixel(input int pat, input int col, input int row);
    case (pat)
      0: return ((col * 13 + row * 7 + col * row) % 5) < 2;
      1: return ((col % 4) == 0) || (((col % 4) == 3) && row[0]);
      default: return row == (col % ROWS);
    endcase
  endfunction

  task automatic fill(input int pat);
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++)
        fb[c * WPC + r / 16][r % 16] = pixel(pat, c, r);
  endtask

  function automatic logic expBit(input int pat, input int s, input int i);
    int n = (s + 1) % STEPS;
    int col = (i % 2 == 0) ? 2 * n : (2 * n + 3) % COLS;
    return pixel(pat, col, i / 2);
  endfunction

  task automatic clearMon();
    capCnt = 0; doneCnt = 0; doneWide = 0;
  endtask

  task automatic pulseStart(input int s);
    @(negedge clk);
    start = 1'b1; stepIdx = 6'(s);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 3000 && doneCnt == 0; i++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic comparePayload(input int pat, input int s, input string req);
    int bad = -1;
    for (int i = 0; i < NBITS; i++)
      if (bad < 0 && capBits[i] !== expBit(pat, s, i)) bad = i;
    check(bad < 0, req, (bad < 0) ? 0 : int'(capBits[bad]), (bad < 0) ? 0 : int'(expBit(pat, s, bad)));
    if (bad >= 0) $display("  first differing bit index %0d (step %0d)", bad, s);
    check(capCnt == NBITS, "R2 edge count", capCnt, NBITS);
    check(doneCnt == 1 && doneWide == 0, "R8 done pulse", doneCnt, 1);
  endtask

  task automatic runStep(input int pat, input int s, input string req);
    fill(pat);
    @(negedge clk);
    clearMon();
    pulseStart(s);
    waitDone();
    comparePayload(pat, s, req);
  endtask

  task automatic testReset();
    check(shiftClk == 1'b0, "R1 shiftClk in reset", shiftClk, 0);
    check(serData == 1'b0, "R1 serData in reset", serData, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
  endtask

  task automatic testParity();
    runStep(0, 4, "R3 R4 R6 random frame step 4");
    runStep(1, 4, "R5 C/B payload odd n");
    runStep(1, 7, "R5 A/D payload even n");
    runStep(2, 20, "R3 diagonal frame step 20");
  endtask

  task automatic testWrap();
    runStep(2, 63, "R10 wrap to step 0");
    runStep(0, 62, "R10 trailing column wraps");
  endtask

  task automatic testBusyStart();
    fill(0);
    @(negedge clk);
    clearMon();
    pulseStart(10);
    repeat (50) @(negedge clk);
    pulseStart(30);
    waitDone();
    comparePayload(0, 10, "R9 payload after busy start");
    repeat (600) @(negedge clk);
    check(capCnt == NBITS, "R9 no extra bits", capCnt, NBITS);
    check(doneCnt == 1, "R9 no extra done", doneCnt, 1);
  endtask

  task automatic testClockShape();
    check(highSeen > 0 && widthErr == 0, "R11 high phase width", widthErr, 0);
    check(lowErr == 0, "R11 low phase width", lowErr, 0);
    check(holdErr == 0, "R7 data held while high", holdErr, 0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=1 expected=0");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testParity();
    testWrap();
    testBusyStart();
    testClockShape();
    finishRun();
  end
endmodule